// File: doc/BRIEF.md
# Second-Level Interrupt Aggregator

This block sits between a set of peripherals and a CPU interrupt controller. Each peripheral raises individual event pulses. The block stores each pulse in a sticky flag and gates the flags with a per-peripheral enable mask. It then merges all enabled flags of one peripheral into a single level request line. Software reads the flags over a small register bus and clears them by writing ones.

For every request line, including the non-maskable one, a missed bit records that a fresh event arrived while that line was already asserted. The non-maskable request passes through the same sticky-flag mechanism. It has exactly two sources, and the enable masks do not apply to it. The first source is a main-crystal failure, taken on the rising edge of a status level. The second is a watchdog low-water timer inside the block. The timer fires once when the watchdog is active and has gone `LWM_TICKS` time ticks without service. At a 1 ms tick, the default value corresponds to 1.792 s.

Top module: `irq_merge_unit`

## Requirements
- R1: A one on `evt_i[p*FLAGS+b]` at a clock edge sets pending flag b of peripheral p. The flag stays set until cleared by software, whether or not it is enabled.
- R2: A bus write to a flag register (pending at addresses 0..NUM_PERIPH-1, missed at 2*NUM_PERIPH, non-maskable at 2*NUM_PERIPH+1) clears exactly the bits written as one. Bits written as zero keep their value.
- R3: When an event and a clearing write hit the same flag in the same cycle, the flag ends up set.
- R4: `irq_o[p]` is high exactly when some pending flag of peripheral p is also enabled. It follows the register state after the same edge that changed it.
- R5: The enable mask of peripheral p is written and read at address NUM_PERIPH+p. It gates only the request; a masked flag still latches and raises the request once the mask is opened.
- R6: Missed bit p (bit p at address 2*NUM_PERIPH) sets when an enabled event for peripheral p arrives while `irq_o[p]` is already high. A masked event or an event on an idle line leaves it clear.
- R7: Non-maskable flag bit 0 sets on a rising edge of `xtal_fail_i`, and bit 1 sets on a watchdog low-water event. `nmi_o` is the OR of both flags, regardless of any enable mask.
- R8: While `wdog_active_i` is high and `wdog_kick_i` is low, each `wdog_tick_i` advances a counter. The low-water event fires on the tick that completes LWM_TICKS ticks and does not repeat. A kick or an inactive watchdog restarts the count from zero.
- R9: After reset all flags, masks and missed bits read zero, and all request outputs are low.
- R10: Missed bit NUM_PERIPH sets when a non-maskable source event arrives while `nmi_o` is already high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| evt_i | input | NUM_PERIPH*FLAGS | Event pulses, FLAGS bits per peripheral, peripheral 0 in the low bits |
| xtal_fail_i | input | 1 | Main crystal failure status level |
| wdog_active_i | input | 1 | Watchdog running |
| wdog_kick_i | input | 1 | Watchdog serviced this cycle |
| wdog_tick_i | input | 1 | Time-base tick for the low-water timer |
| bus_wr_i | input | 1 | Register write strobe |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | FLAGS | Write data |
| bus_rdata_o | output | FLAGS | Read data for `bus_addr_i`, combinational |
| irq_o | output | NUM_PERIPH | Per-peripheral level requests |
| nmi_o | output | 1 | Non-maskable level request |

## Verification
Every stored result (flags, masks, missed bits) updates at the clock edge that samples the event or write, and `irq_o`, `nmi_o` and read data reflect it right after that same edge. The bench therefore changes inputs on the falling edge, lets exactly one rising edge pass, and compares on the next falling edge. Read data is combinational, so a read needs no extra cycle. The low-water event is due on the LWM_TICKS-th ticking edge after the count restarts, so the bench checks `nmi_o` low after one edge fewer and high after that edge.

// File: rtl/irq_merge_pkg.sv
// Package: shared register-region type and address classifier for the
// second-level interrupt aggregator.
// Assumes the map: pending flags, then enable masks, then missed, then NMI.
package irq_merge_pkg;

    typedef enum logic [2:0] {
        REG_PEND,
        REG_MASK,
        REG_MISS,
        REG_NMI,
        REG_VOID
    } reg_kind_e;

    // Map a register address to its region for a given peripheral count.
    function automatic reg_kind_e classify(input int unsigned addr,
                                           input int unsigned nper);
        if (addr < nper)               return REG_PEND;
        else if (addr < 2 * nper)      return REG_MASK;
        else if (addr == 2 * nper)     return REG_MISS;
        else if (addr == 2 * nper + 1) return REG_NMI;
        else                           return REG_VOID;
    endfunction

endpackage

// File: rtl/irq_lane.sv
// Module: one peripheral's second-level flags.
// Keeps sticky pending flags (set wins over a write-one clear) and an enable
// mask. Produces the ORed level request and a pulse telling that an enabled
// event arrived this cycle.
// Assumes clr_i is already zero unless this lane's pending register is written.
module irq_lane #(
    parameter int FLAGS = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [FLAGS-1:0] evt_i,
    input  logic [FLAGS-1:0] clr_i,
    input  logic             mask_wr_i,
    input  logic [FLAGS-1:0] mask_data_i,
    output logic [FLAGS-1:0] pend_o,
    output logic [FLAGS-1:0] mask_o,
    output logic             req_o,
    output logic             hit_o
);

    logic [FLAGS-1:0] pend_q;
    logic [FLAGS-1:0] mask_q;

    // Sticky flags: clear the written ones, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= (pend_q & ~clr_i) | evt_i;
    end

    // Enable mask: plain register written from the bus.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (mask_wr_i) mask_q <= mask_data_i;
    end

    // Request and enabled-arrival pulse.
    always_comb begin
        req_o = |(pend_q & mask_q);
        hit_o = |(evt_i & mask_q);
    end

    assign pend_o = pend_q;
    assign mask_o = mask_q;

endmodule

// File: rtl/irq_miss_tracker.sv
// Module: missed-event bits, one per top-level request line.
// A bit sets when an arrival pulse meets a line that is already requesting.
// A bit clears when software writes one to it; set wins over clear.
// Assumes busy_i holds the registered request levels of the lines.
module irq_miss_tracker #(
    parameter int LINES = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] hit_i,
    input  logic [LINES-1:0] busy_i,
    input  logic [LINES-1:0] clr_i,
    output logic [LINES-1:0] miss_o
);

    logic [LINES-1:0] miss_q;

    // Record arrivals on busy lines, clear on write-one.
    always_ff @(posedge clk) begin
        if (!rst_n) miss_q <= '0;
        else        miss_q <= (miss_q & ~clr_i) | (hit_i & busy_i);
    end

    assign miss_o = miss_q;

endmodule

// File: rtl/wdog_lowwater.sv
// Module: watchdog low-water timer.
// Counts time-base ticks while the watchdog is active and unserviced, and
// pulses fire_o on the tick that completes LWM_TICKS. It then holds the
// count, so the event does not repeat until a kick or deactivation restarts it.
// Assumes LWM_TICKS >= 1.
module wdog_lowwater #(
    parameter int LWM_TICKS = 1792
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active_i,
    input  logic kick_i,
    input  logic tick_i,
    output logic fire_o
);

    localparam int CW = $clog2(LWM_TICKS + 1);
    localparam logic [CW-1:0] LIMIT = CW'(LWM_TICKS);
    localparam logic [CW-1:0] LAST  = CW'(LWM_TICKS - 1);

    logic [CW-1:0] cnt_q;

    // Tick counter, restarted by a kick or an inactive watchdog, saturating.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cnt_q <= '0;
        else if (!active_i || kick_i)  cnt_q <= '0;
        else if (tick_i && cnt_q != LIMIT) cnt_q <= cnt_q + 1'b1;
    end

    // Event on the tick that reaches the limit.
    always_comb begin
        fire_o = active_i && !kick_i && tick_i && (cnt_q == LAST);
    end

endmodule

// File: rtl/nmi_src.sv
// Module: non-maskable request sources.
// Bit 0 latches a rising edge of the crystal-failure level, bit 1 latches the
// low-water event. No mask applies. Flags are sticky with write-one clear.
// Assumes clr_i is zero unless the non-maskable register is written.
module nmi_src (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       xtal_fail_i,
    input  logic       lowwater_i,
    input  logic [1:0] clr_i,
    output logic [1:0] flags_o,
    output logic       req_o,
    output logic       hit_o
);

    logic       fail_prev_q;
    logic [1:0] flags_q;
    logic [1:0] src;

    // Previous crystal status for rising-edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) fail_prev_q <= 1'b0;
        else        fail_prev_q <= xtal_fail_i;
    end

    // Source events of this cycle.
    always_comb begin
        src = {lowwater_i, xtal_fail_i & ~fail_prev_q};
    end

    // Sticky flags, set wins over clear.
    always_ff @(posedge clk) begin
        if (!rst_n) flags_q <= '0;
        else        flags_q <= (flags_q & ~clr_i) | src;
    end

    assign flags_o = flags_q;
    assign req_o   = |flags_q;
    assign hit_o   = |src;

endmodule

// File: rtl/irq_merge_unit.sv
// Module: second-level interrupt aggregator (top).
// One lane per peripheral merges its enabled sticky flags into irq_o[p]. A
// tracker records missed arrivals for every line including the non-maskable
// one. The non-maskable line takes a crystal-failure edge and a watchdog
// low-water event. The register bus writes and reads in one cycle.
// Map: pending p at p, mask p at NUM_PERIPH+p, missed at 2*NUM_PERIPH,
// non-maskable flags at 2*NUM_PERIPH+1. Assumes FLAGS >= NUM_PERIPH+1.
module irq_merge_unit
    import irq_merge_pkg::*;
#(
    parameter int NUM_PERIPH = 4,
    parameter int FLAGS      = 8,
    parameter int LWM_TICKS  = 1792,
    localparam int ADDR_W    = $clog2(2 * NUM_PERIPH + 2),
    localparam int EVT_W     = NUM_PERIPH * FLAGS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [EVT_W-1:0]  evt_i,
    input  logic              xtal_fail_i,
    input  logic              wdog_active_i,
    input  logic              wdog_kick_i,
    input  logic              wdog_tick_i,
    input  logic              bus_wr_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [FLAGS-1:0]  bus_wdata_i,
    output logic [FLAGS-1:0]  bus_rdata_o,
    output logic [NUM_PERIPH-1:0] irq_o,
    output logic              nmi_o
);

    localparam int LINES = NUM_PERIPH + 1;

    reg_kind_e               kind;
    logic [FLAGS-1:0]        pend_arr [NUM_PERIPH];
    logic [FLAGS-1:0]        mask_arr [NUM_PERIPH];
    logic [EVT_W-1:0]        pend_flat;
    logic [NUM_PERIPH-1:0]   lane_hit;
    logic [LINES-1:0]        miss_q;
    logic [LINES-1:0]        miss_clr;
    logic [1:0]              nmi_flags;
    logic [1:0]              nmi_clr;
    logic                    nmi_hit;
    logic                    lowwater;

    // Classify the bus address into a register region.
    always_comb begin
        kind = classify(32'(bus_addr_i), 32'(NUM_PERIPH));
    end

    // One lane per peripheral.
    for (genvar p = 0; p < NUM_PERIPH; p++) begin : g_lane
        logic [FLAGS-1:0] clr;
        logic             mwr;

        // Per-lane write decode.
        always_comb begin
            clr = (bus_wr_i && bus_addr_i == ADDR_W'(p)) ? bus_wdata_i : '0;
            mwr = bus_wr_i && (bus_addr_i == ADDR_W'(NUM_PERIPH + p));
        end

        irq_lane #(.FLAGS(FLAGS)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .evt_i       (evt_i[p*FLAGS +: FLAGS]),
            .clr_i       (clr),
            .mask_wr_i   (mwr),
            .mask_data_i (bus_wdata_i),
            .pend_o      (pend_arr[p]),
            .mask_o      (mask_arr[p]),
            .req_o       (irq_o[p]),
            .hit_o       (lane_hit[p])
        );

        assign pend_flat[p*FLAGS +: FLAGS] = pend_arr[p];
    end

    // Write-one clear strobes for missed and non-maskable registers.
    always_comb begin
        miss_clr = (bus_wr_i && kind == REG_MISS) ? bus_wdata_i[LINES-1:0] : '0;
        nmi_clr  = (bus_wr_i && kind == REG_NMI)  ? bus_wdata_i[1:0]       : '0;
    end

    wdog_lowwater #(.LWM_TICKS(LWM_TICKS)) u_lwm (
        .clk      (clk),
        .rst_n    (rst_n),
        .active_i (wdog_active_i),
        .kick_i   (wdog_kick_i),
        .tick_i   (wdog_tick_i),
        .fire_o   (lowwater)
    );

    nmi_src u_nmi (
        .clk         (clk),
        .rst_n       (rst_n),
        .xtal_fail_i (xtal_fail_i),
        .lowwater_i  (lowwater),
        .clr_i       (nmi_clr),
        .flags_o     (nmi_flags),
        .req_o       (nmi_o),
        .hit_o       (nmi_hit)
    );

    irq_miss_tracker #(.LINES(LINES)) u_miss (
        .clk    (clk),
        .rst_n  (rst_n),
        .hit_i  ({nmi_hit, lane_hit}),
        .busy_i ({nmi_o, irq_o}),
        .clr_i  (miss_clr),
        .miss_o (miss_q)
    );

    // Read multiplexer.
    always_comb begin
        bus_rdata_o = '0;
        unique case (kind)
            REG_PEND: begin
                for (int p = 0; p < NUM_PERIPH; p++)
                    if (bus_addr_i == ADDR_W'(p)) bus_rdata_o = pend_arr[p];
            end
            REG_MASK: begin
                for (int p = 0; p < NUM_PERIPH; p++)
                    if (bus_addr_i == ADDR_W'(NUM_PERIPH + p)) bus_rdata_o = mask_arr[p];
            end
            REG_MISS: bus_rdata_o[LINES-1:0] = miss_q;
            REG_NMI:  bus_rdata_o[1:0]       = nmi_flags;
            default:  bus_rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irq_merge_checker.sv
// Module: property checker for irq_merge_unit, attached by bind.
// Observes ports and the flag registers; drives nothing.
module irq_merge_checker #(
    parameter int NUM_PERIPH = 4,
    parameter int FLAGS      = 8,
    localparam int EVT_W     = NUM_PERIPH * FLAGS,
    localparam int LINES     = NUM_PERIPH + 1
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [EVT_W-1:0]      evt_i,
    input logic                  bus_wr_i,
    input logic                  xtal_fail_i,
    input logic                  wdog_active_i,
    input logic [NUM_PERIPH-1:0] irq_o,
    input logic                  nmi_o,
    input logic [EVT_W-1:0]      pend_flat,
    input logic [LINES-1:0]      miss_q,
    input logic [1:0]            nmi_flags
);

    logic [LINES-1:0] busy;
    assign busy = {nmi_o, irq_o};

    // Without a write, no pending flag may drop.
    assert_sticky_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(bus_wr_i)) |-> (($past(pend_flat) & ~pend_flat) == '0));

    // An event always leaves its flag set, even against a clear.
    assert_set_wins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (($past(evt_i) & ~pend_flat) == '0));

    // A request rises only after an event or a mask write.
    assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && |(irq_o & ~$past(irq_o))) |-> ($past(|evt_i) || $past(bus_wr_i)));

    // A request falls only after a bus write.
    assert_irq_fall_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && |($past(irq_o) & ~irq_o)) |-> $past(bus_wr_i));

    // A crystal failure edge raises the non-maskable request next cycle.
    assert_nmi_xtal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(xtal_fail_i)) |=> nmi_o);

    // Low-water flag only rises while the watchdog is active.
    assert_lowwater_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $rose(nmi_flags[1])) |-> $past(wdog_active_i));

    // A missed bit rises only on a line that was already requesting (R6, R10).
    for (genvar i = 0; i < LINES; i++) begin : g_miss
        assert_miss_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
            ($past(rst_n) && $rose(miss_q[i])) |-> $past(busy[i]));
    end

endmodule

bind irq_merge_unit irq_merge_checker #(
    .NUM_PERIPH (NUM_PERIPH),
    .FLAGS      (FLAGS)
) u_irq_merge_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .evt_i         (evt_i),
    .bus_wr_i      (bus_wr_i),
    .xtal_fail_i   (xtal_fail_i),
    .wdog_active_i (wdog_active_i),
    .irq_o         (irq_o),
    .nmi_o         (nmi_o),
    .pend_flat     (pend_flat),
    .miss_q        (miss_q),
    .nmi_flags     (nmi_flags)
);

// File: tb/irq_merge_unit_bench.sv
// Bench: vector table for masking and clearing, then directed corner tests.
module irq_merge_unit_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NP  = 4;
    localparam int FL  = 8;
    localparam int LWM = 20;
    localparam int AW  = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NP*FL-1:0] evt = '0;
    logic          xtal = 1'b0;
    logic          wact = 1'b0;
    logic          wkick = 1'b0;
    logic          wtick = 1'b0;
    logic          wr = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [FL-1:0] wdata = '0;
    logic [FL-1:0] rdata;
    logic [NP-1:0] irq;
    logic          nmi;

    int compared = 0;
    int mismatched = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    irq_merge_unit #(.NUM_PERIPH(NP), .FLAGS(FL), .LWM_TICKS(LWM)) u_irq_merge_unit (
        .clk(clk), .rst_n(rst_n), .evt_i(evt), .xtal_fail_i(xtal),
        .wdog_active_i(wact), .wdog_kick_i(wkick), .wdog_tick_i(wtick),
        .bus_wr_i(wr), .bus_addr_i(addr), .bus_wdata_i(wdata),
        .bus_rdata_o(rdata), .irq_o(irq), .nmi_o(nmi)
    );

    // Vector: evt[48:17] wr[16] addr[15:12] data[11:4] expected irq[3:0]
    localparam logic [48:0] VEC [13] = '{
        {32'h0000_0000, 1'b1, 4'd4, 8'hFF, 4'b0000},
        {32'h0000_0000, 1'b1, 4'd5, 8'h0F, 4'b0000},
        {32'h0000_0000, 1'b1, 4'd6, 8'h01, 4'b0000},
        {32'h0000_0000, 1'b1, 4'd7, 8'h80, 4'b0000},
        {32'h0000_0008, 1'b0, 4'd0, 8'h00, 4'b0001},
        {32'h0000_1000, 1'b0, 4'd0, 8'h00, 4'b0001},
        {32'h0001_0000, 1'b0, 4'd0, 8'h00, 4'b0101},
        {32'h0000_0000, 1'b1, 4'd0, 8'h08, 4'b0100},
        {32'h8000_0000, 1'b1, 4'd2, 8'h01, 4'b1000},
        {32'h0000_0000, 1'b1, 4'd3, 8'h00, 4'b1000},
        {32'h0000_0000, 1'b1, 4'd5, 8'hFF, 4'b1010},
        {32'h0000_0000, 1'b1, 4'd1, 8'h10, 4'b1000},
        {32'h0000_0000, 1'b1, 4'd3, 8'h80, 4'b0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (act !== exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // One rising edge, then back to the falling edge for sampling.
    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input int a, input int d);
        wr = 1'b1; addr = AW'(a); wdata = FL'(d);
        cyc();
        wr = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int a, input int exp);
        addr = AW'(a);
        #1;
        chk(tag, 32'(rdata), 32'(exp));
    endtask

    // Watchdog: a hung run counts as a failure and still summarises.
    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            mismatched++;
            compared++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R9: reset state of every register and output.
        for (int a = 0; a < 2*NP+2; a++) rd_chk("R9 reset reg", a, 0);
        chk("R9 reset irq", 32'(irq), 0);
        chk("R9 reset nmi", 32'(nmi), 0);

        // Table walk: R1 flags, R2 clears, R4 merge, R5 masks.
        for (int i = 0; i < 13; i++) begin
            evt   = VEC[i][48:17];
            wr    = VEC[i][16];
            addr  = VEC[i][15:12];
            wdata = VEC[i][11:4];
            cyc();
            evt = '0; wr = 1'b0;
            chk($sformatf("R4 R5 R1 R2 vector %0d irq", i), 32'(irq), 32'(VEC[i][3:0]));
        end
        rd_chk("R5 mask readback p1", 5, 8'hFF);
        rd_chk("R6 masked or idle events leave missed clear", 2*NP, 0);

        // R3: event and clear on the same flag, same cycle.
        evt = 32'h0000_0002; wr = 1'b1; addr = 0; wdata = 8'h02;
        cyc();
        evt = '0; wr = 1'b0;
        rd_chk("R3 set wins", 0, 8'h02);
        chk("R3 irq after set-wins", 32'(irq), 4'b0001);

        // R6: enabled event on a busy line.
        evt = 32'h0000_0004;
        cyc();
        evt = '0;
        rd_chk("R6 missed set", 2*NP, 8'h01);
        rd_chk("R1 flags accumulate", 0, 8'h06);
        bus_write(2*NP, 0);
        rd_chk("R2 zero write keeps missed", 2*NP, 8'h01);
        bus_write(2*NP, 1);
        rd_chk("R6 missed cleared by one", 2*NP, 0);
        bus_write(0, 8'h06);
        chk("R4 irq drops after clear", 32'(irq), 0);

        // R7: masks closed, crystal failure still requests.
        for (int p = 0; p < NP; p++) bus_write(NP + p, 0);
        xtal = 1'b1;
        cyc();
        chk("R7 nmi on crystal edge", 32'(nmi), 1);
        rd_chk("R7 crystal flag bit0", 2*NP+1, 8'h01);
        chk("R7 no peripheral irq", 32'(irq), 0);

        // R10: second crystal edge while nmi is pending.
        xtal = 1'b0; cyc();
        xtal = 1'b1; cyc();
        rd_chk("R10 nmi missed bit", 2*NP, 8'h10);
        bus_write(2*NP, 8'h10);
        bus_write(2*NP+1, 8'h01);
        chk("R2 nmi cleared with level still high", 32'(nmi), 0);
        xtal = 1'b0;

        // R8: low-water timer.
        wact = 1'b1; wtick = 1'b1;
        repeat (LWM-1) cyc();
        chk("R8 no event one tick early", 32'(nmi), 0);
        cyc();
        chk("R8 event at limit", 32'(nmi), 1);
        rd_chk("R8 low-water flag bit1", 2*NP+1, 8'h02);
        bus_write(2*NP+1, 8'h02);
        repeat (10) cyc();
        chk("R8 no repeat while saturated", 32'(nmi), 0);
        wkick = 1'b1; cyc(); wkick = 1'b0;
        repeat (LWM-1) cyc();
        chk("R8 kick restarts count", 32'(nmi), 0);
        cyc();
        chk("R8 event after restart", 32'(nmi), 1);
        wact = 1'b0; wtick = 1'b0;

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

endmodule